// File: doc/BRIEF.md
# Parallel Byte-Wide Flash Programming Port

This block models the on-chip side of a parallel programming mode for a 2K-byte code store. An external programmer selects an operation with four mode pins and a high-voltage enable, steps an internal 11-bit address counter with pulses on a stepping pin, and moves data through an 8-bit input bus and an 8-bit output bus. All pins are taken as already synchronous to the block clock.

Writes of code bytes and lock bits are self-timed. The programmer gives one low pulse on the active-low program strobe. The block then holds its ready line low for a set number of clock cycles and commits the operation at the end. While a code byte write is in progress, a read of the byte being written returns the inverse of its bit 7 on the output MSB, so the programmer can poll for completion. A chip erase needs the strobe held low for a set hold time. It then sweeps every byte to 0xFF, one byte per clock, and clears both lock bits. Two lock bits refuse further code programming and then refuse code reads. Signature bytes stay readable in every lock state.

Top module: `flash_prog_if`

## Requirements
- R1: The address counter is cleared on each rising edge of `en_pin`. It advances by one on each rising edge of `step_pin` while `en_pin` is high, and it wraps from 0x7FF to 0x000.
- R2: `mode_pins` (bits 3..0) select the operation. With `hv_pin` high: 0111 writes a code byte, 1111 programs lock bit 1, 1100 programs lock bit 2, and 1000 erases the chip. With `hv_pin` low: 0011 reads code and 0000 reads signature. Any other combination, or `en_pin` low, selects nothing, and a strobe pulse then has no effect.
- R3: A low pulse on `prog_n` in a write mode latches `data_in` and the address on its falling edge. From the clock after the rising edge, `ready` stays low for exactly WRITE_CYC cycles. The byte is stored when `ready` returns high.
- R4: While a code write is in progress, a code read of its address returns the inverse of the written bit 7 on bit 7 of `data_out`, with bits 6..0 equal to zero. After completion the stored byte is returned.
- R5: A code write can only clear bits. The stored result is the old byte ANDed with the new byte.
- R6: In erase mode, holding `prog_n` low for ERASE_HOLD consecutive cycles drives `ready` low while every byte is set to 0xFF, one per cycle. Both lock bits are then cleared. A shorter hold changes nothing.
- R7: A signature read returns 0x1E at address 0x000, 0x21 at address 0x001 and 0xFF at every other address.
- R8: Once lock bit 1 is set, a code write pulse is refused: `ready` stays high and the byte is unchanged.
- R9: Once lock bit 2 is set, code reads return 0xFF. Signature reads are unaffected.
- R10: When no read mode is selected, `data_out` is 0xFF.
- R11: After reset `ready` is high, `data_out` is 0xFF, both lock bits are clear and the array reads blank (0xFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Logic-level enable; its rising edge clears the address counter |
| hv_pin | input | 1 | High-voltage programming enable present |
| step_pin | input | 1 | Address counter advance, rising-edge active |
| prog_n | input | 1 | Active-low program strobe |
| mode_pins | input | 4 | Operation select pattern |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Read data, signature or polling status |
| ready | output | 1 | High when idle, low while a write or erase is running |

## Verification
Code writes are run with data whose bit 7 is both 1 and 0, and onto blank and non-blank bytes. This separates the polling value from the stored value and shows the AND behaviour on overwrite. Strobe pulses are also given in a decoded write mode, in an undecoded pattern, and with lock bit 1 set. The length of the busy window then tells an accepted write from a refused one. Erase is tried with a hold that is too short and with a full hold, and a write at the top address followed by one step shows whether the counter wraps.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  typedef enum logic [2:0] {
    MD_NONE,
    MD_READ,
    MD_SIG,
    MD_CODE,
    MD_LOCK1,
    MD_LOCK2,
    MD_ERASE
  } fpi_mode_e;

  localparam logic [3:0] PAT_CODE  = 4'b0111;
  localparam logic [3:0] PAT_LOCK1 = 4'b1111;
  localparam logic [3:0] PAT_LOCK2 = 4'b1100;
  localparam logic [3:0] PAT_ERASE = 4'b1000;
  localparam logic [3:0] PAT_READ  = 4'b0011;
  localparam logic [3:0] PAT_SIG   = 4'b0000;

  localparam logic [7:0] SIG_B0 = 8'h1E;
  localparam logic [7:0] SIG_B1 = 8'h21;
  localparam logic [7:0] BLANK  = 8'hFF;

  function automatic fpi_mode_e fpi_decode(input logic en, input logic hv,
                                           input logic [3:0] pins);
    fpi_mode_e m;
    m = MD_NONE;
    if (en && hv) begin
      if (pins == PAT_CODE)       m = MD_CODE;
      else if (pins == PAT_LOCK1) m = MD_LOCK1;
      else if (pins == PAT_LOCK2) m = MD_LOCK2;
      else if (pins == PAT_ERASE) m = MD_ERASE;
    end else if (en) begin
      if (pins == PAT_READ)       m = MD_READ;
      else if (pins == PAT_SIG)   m = MD_SIG;
    end
    return m;
  endfunction

endpackage

// File: rtl/fpi_addr_ctr.sv
module fpi_addr_ctr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic en_q, step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      step_q <= 1'b0;
      addr   <= '0;
    end else begin
      en_q   <= en;
      step_q <= step;
      if (en && !en_q)
        addr <= '0;
      else if (en && step && !step_q)
        addr <= addr + 1'b1;
    end
  end

  // R1
  addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !en_q) |=> (addr == '0));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && en_q && step && !step_q) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/fpi_array.sv
module fpi_array #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fpi_pkg::BLANK;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fpi_ctrl.sv
module fpi_ctrl
  import fpi_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DEPTH      = 2048,
  parameter int WRITE_CYC  = 60000,
  parameter int ERASE_HOLD = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  fpi_mode_e         mode,
  input  logic              prog_n,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mem_q,
  output logic              ready,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              lock1,
  output logic              lock2,
  output logic              poll_act,
  output logic [ADDR_W-1:0] poll_addr,
  output logic              poll_bit
);
  localparam int TMR_W  = $clog2(WRITE_CYC + 1);
  localparam int HOLD_W = $clog2(ERASE_HOLD + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [TMR_W-1:0]  TMR_LOAD  = TMR_W'(WRITE_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(ERASE_HOLD - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_SWEEP} st_e;

  st_e               state;
  logic              prog_q, pend;
  fpi_mode_e         kind;
  logic [7:0]        lat_d, wr_byte;
  logic [ADDR_W-1:0] lat_a, sweep;
  logic [TMR_W-1:0]  tmr;
  logic [HOLD_W-1:0] hold;
  logic              prog_fall, prog_rise, accept;

  assign prog_fall = !prog_n && prog_q;
  assign prog_rise = prog_n && !prog_q;
  assign accept    = (mode == MD_LOCK1) || (mode == MD_LOCK2) ||
                     ((mode == MD_CODE) && !lock1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ready   <= 1'b1;
      prog_q  <= 1'b1;
      pend    <= 1'b0;
      kind    <= MD_NONE;
      lat_d   <= '0;
      lat_a   <= '0;
      wr_byte <= '0;
      tmr     <= '0;
      hold    <= '0;
      sweep   <= '0;
      lock1   <= 1'b0;
      lock2   <= 1'b0;
    end else begin
      prog_q <= prog_n;
      case (state)
        S_IDLE: begin
          if (prog_fall && accept) begin
            pend  <= 1'b1;
            kind  <= mode;
            lat_d <= din;
            lat_a <= addr;
          end
          if (prog_rise && pend) begin
            pend    <= 1'b0;
            state   <= S_BUSY;
            ready   <= 1'b0;
            tmr     <= TMR_LOAD;
            wr_byte <= lat_d & mem_q;
          end
          if (mode == MD_ERASE && !prog_n) begin
            if (hold == HOLD_LAST) begin
              state <= S_SWEEP;
              ready <= 1'b0;
              hold  <= '0;
              sweep <= '0;
              pend  <= 1'b0;
            end else begin
              hold <= hold + 1'b1;
            end
          end else begin
            hold <= '0;
          end
        end
        S_BUSY: begin
          if (tmr == '0) begin
            state <= S_IDLE;
            ready <= 1'b1;
            if (kind == MD_LOCK1) lock1 <= 1'b1;
            if (kind == MD_LOCK2) lock2 <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: begin
          if (sweep == LAST_ADDR) begin
            state <= S_IDLE;
            ready <= 1'b1;
            lock1 <= 1'b0;
            lock2 <= 1'b0;
          end else begin
            sweep <= sweep + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    we        = (state == S_SWEEP) ||
                ((state == S_BUSY) && (tmr == '0) && (kind == MD_CODE));
    waddr     = (state == S_SWEEP) ? sweep : lat_a;
    wdata     = (state == S_SWEEP) ? BLANK : wr_byte;
    poll_act  = (state == S_BUSY) && (kind == MD_CODE);
    poll_addr = lat_a;
    poll_bit  = ~wr_byte[7];
  end

  // R8
  lock_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !pend && lock1 && mode == MD_CODE && prog_rise) |=> ready);

  // R6
  erase_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SWEEP && sweep == LAST_ADDR) |=> (ready && !lock1 && !lock2));

  // R3
  commit_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (we && state == S_BUSY) |=> ready);

endmodule

// File: rtl/fpi_rdmux.sv
module fpi_rdmux
  import fpi_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  fpi_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock2,
  input  logic              poll_act,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              poll_bit,
  input  logic [7:0]        mem_q,
  output logic [7:0]        data_out
);
  fpi_mode_e  k1;
  logic [7:0] sig1;
  logic       poll1, pb1, lk1;

  always_ff @(posedge clk) begin
    if (rst) begin
      k1    <= MD_NONE;
      sig1  <= BLANK;
      poll1 <= 1'b0;
      pb1   <= 1'b0;
      lk1   <= 1'b0;
    end else begin
      k1    <= mode;
      sig1  <= (addr == '0) ? SIG_B0 :
               (addr == ADDR_W'(1)) ? SIG_B1 : BLANK;
      poll1 <= poll_act && (addr == poll_addr);
      pb1   <= poll_bit;
      lk1   <= lock2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= BLANK;
    end else begin
      case (k1)
        MD_READ: data_out <= lk1 ? BLANK : (poll1 ? {pb1, 7'b0} : mem_q);
        MD_SIG:  data_out <= sig1;
        default: data_out <= BLANK;
      endcase
    end
  end

  // R9
  lock_read_chk: assert property (@(posedge clk) disable iff (rst)
    (k1 == MD_READ && lk1) |=> (data_out == BLANK));

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (k1 != MD_READ && k1 != MD_SIG) |=> (data_out == BLANK));

endmodule

// File: rtl/flash_prog_if.sv
module flash_prog_if
  import fpi_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int WRITE_CYC  = 60000,
  parameter int ERASE_HOLD = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_pin,
  input  logic       hv_pin,
  input  logic       step_pin,
  input  logic       prog_n,
  input  logic [3:0] mode_pins,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       ready
);
  localparam int ADDR_W = $clog2(DEPTH);

  fpi_mode_e         mode;
  logic [ADDR_W-1:0] addr, waddr, poll_addr;
  logic [7:0]        mem_q, wdata;
  logic              we, lock1, lock2, poll_act, poll_bit;

  assign mode = fpi_decode(en_pin, hv_pin, mode_pins);

  fpi_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .en(en_pin), .step(step_pin), .addr(addr)
  );

  fpi_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(addr), .rdata(mem_q)
  );

  fpi_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WRITE_CYC(WRITE_CYC),
             .ERASE_HOLD(ERASE_HOLD)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .prog_n(prog_n), .din(data_in),
    .addr(addr), .mem_q(mem_q), .ready(ready), .we(we), .waddr(waddr),
    .wdata(wdata), .lock1(lock1), .lock2(lock2), .poll_act(poll_act),
    .poll_addr(poll_addr), .poll_bit(poll_bit)
  );

  fpi_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .mode(mode), .addr(addr), .lock2(lock2),
    .poll_act(poll_act), .poll_addr(poll_addr), .poll_bit(poll_bit),
    .mem_q(mem_q), .data_out(data_out)
  );

endmodule

// File: tb/tb_flash_prog_if.sv
module tb_flash_prog_if;
  localparam int W     = 40;
  localparam int EH    = 30;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_pin = 1'b0, hv_pin = 1'b0, step_pin = 1'b0, prog_n = 1'b1;
  logic [3:0] mode_pins = 4'b0101;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic ready;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic smp = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  flash_prog_if #(.DEPTH(DEPTH), .WRITE_CYC(W), .ERASE_HOLD(EH)) dut (
    .clk(clk), .rst(rst), .en_pin(en_pin), .hv_pin(hv_pin),
    .step_pin(step_pin), .prog_n(prog_n), .mode_pins(mode_pins),
    .data_in(data_in), .data_out(data_out), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (smp) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(data_out == e, t, data_out, e);
    end
  end

  task automatic expect_out(input logic [7:0] v, input string tag);
    repeat (4) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    smp <= 1'b1;
    @(posedge clk);
    smp <= 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pins(input logic hv, input logic [3:0] m);
    @(negedge clk);
    hv_pin = hv;
    mode_pins = m;
  endtask

  task automatic step_once();
    @(negedge clk) step_pin = 1'b1;
    @(negedge clk) step_pin = 1'b0;
  endtask

  task automatic goto_addr(input int a);
    @(negedge clk) en_pin = 1'b0;
    @(negedge clk) en_pin = 1'b1;
    for (int i = 0; i < a; i++) step_once();
  endtask

  task automatic prog_pulse(input logic [7:0] d);
    @(negedge clk);
    data_in = d;
    prog_n = 1'b0;
    repeat (3) @(negedge clk);
    prog_n = 1'b1;
  endtask

  task automatic wait_ready(output int cnt);
    cnt = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (ready) break;
      cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R11 ready after reset", ready, 1);
    check(data_out == 8'hFF, "R11 data_out after reset", data_out, 8'hFF);

    // signature
    set_pins(1'b0, 4'b0000);
    goto_addr(0);
    expect_out(8'h1E, "R7 signature addr 0");
    step_once();
    expect_out(8'h21, "R7 signature addr 1");
    step_once();
    expect_out(8'hFF, "R7 signature addr 2");

    // blank array
    set_pins(1'b0, 4'b0011);
    goto_addr(0);
    expect_out(8'hFF, "R11 blank array");

    // write 0xF0 at 6, busy length
    set_pins(1'b1, 4'b0111);
    goto_addr(6);
    prog_pulse(8'hF0);
    wait_ready(c);
    check(c == W, "R3 busy length", c, W);
    set_pins(1'b0, 4'b0011);
    expect_out(8'hF0, "R3 stored byte");

    // overwrite without erase
    set_pins(1'b1, 4'b0111);
    prog_pulse(8'h0F);
    wait_ready(c);
    set_pins(1'b0, 4'b0011);
    expect_out(8'h00, "R5 AND on overwrite");

    // no read mode
    set_pins(1'b0, 4'b0101);
    expect_out(8'hFF, "R10 undecoded pattern");

    // short erase hold
    set_pins(1'b1, 4'b1000);
    @(negedge clk) prog_n = 1'b0;
    repeat (10) @(negedge clk);
    prog_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R6 short hold keeps ready", ready, 1);
    set_pins(1'b0, 4'b0011);
    expect_out(8'h00, "R6 short hold no erase");

    // data polling at 5
    set_pins(1'b1, 4'b0111);
    goto_addr(5);
    prog_pulse(8'h35);
    @(negedge clk);
    hv_pin = 1'b0;
    mode_pins = 4'b0011;
    expect_out(8'h80, "R4 polling value");
    wait_ready(c);
    expect_out(8'h35, "R4 true data after write");

    // wrap at top
    set_pins(1'b1, 4'b0111);
    goto_addr(DEPTH - 1);
    prog_pulse(8'h3C);
    wait_ready(c);
    set_pins(1'b0, 4'b0011);
    expect_out(8'h3C, "R1 top address");
    step_once();
    expect_out(8'hFF, "R1 wrap to 0");

    // pulse with no high voltage
    set_pins(1'b0, 4'b0111);
    goto_addr(5);
    prog_pulse(8'h00);
    wait_ready(c);
    check(c == 0, "R2 no write without hv", c, 0);
    set_pins(1'b0, 4'b0011);
    expect_out(8'h35, "R2 byte unchanged");

    // lock bit 1
    set_pins(1'b1, 4'b1111);
    prog_pulse(8'h00);
    wait_ready(c);
    check(c == W, "R8 lock1 programming busy", c, W);
    set_pins(1'b1, 4'b0111);
    goto_addr(7);
    prog_pulse(8'h12);
    wait_ready(c);
    check(c == 0, "R8 write refused", c, 0);
    set_pins(1'b0, 4'b0011);
    expect_out(8'hFF, "R8 byte unchanged");

    // lock bit 2
    set_pins(1'b1, 4'b1100);
    prog_pulse(8'h00);
    wait_ready(c);
    set_pins(1'b0, 4'b0011);
    goto_addr(5);
    expect_out(8'hFF, "R9 code read refused");
    set_pins(1'b0, 4'b0000);
    goto_addr(0);
    expect_out(8'h1E, "R9 signature still readable");

    // full erase
    set_pins(1'b1, 4'b1000);
    @(negedge clk) prog_n = 1'b0;
    repeat (EH + 5) @(negedge clk);
    check(ready == 1'b0, "R6 busy during sweep", ready, 0);
    prog_n = 1'b1;
    wait_ready(c);
    set_pins(1'b0, 4'b0011);
    goto_addr(5);
    expect_out(8'hFF, "R6 erased addr 5");
    step_once();
    expect_out(8'hFF, "R6 erased addr 6");
    set_pins(1'b1, 4'b0111);
    goto_addr(7);
    prog_pulse(8'h12);
    wait_ready(c);
    check(c == W, "R6 locks cleared write accepted", c, W);
    set_pins(1'b0, 4'b0011);
    expect_out(8'h12, "R6 write after erase");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule